// File: doc/BRIEF.md
# RAM Wipe Sequencer

This block erases a small battery-backed user memory on request from an active-low external pin. The pin is only honoured when a wipe-enable bit in a control register is set; a request then makes the block take over the memory's write port and store zero at every user location, one location per clock, in ascending address order.

When the pass finishes, the block sets a completion flag. If a separate interrupt-enable bit is set, it also pulls an active-low interrupt line low. Software clears the flag and the interrupt either by reading the flag or by writing 1 to it. While a pass is running, host accesses to the memory are locked out: host writes are dropped and host reads return zero. The memory array itself sits outside the block.

Top module: `ram_wipe_seq`

## Requirements
- R1: A wipe pass writes every address from 0 to DEPTH-1 (DEPTH = 242 by default) and no other address. Host data at addresses DEPTH and above is left unchanged.
- R2: A falling edge of `wipe_n`, after a two-flop synchroniser, starts a pass only when the wipe-enable bit is 1. `busy` rises on the third rising clock edge after `wipe_n` goes low.
- R3: When the wipe-enable bit is 0, a low level on `wipe_n` has no effect: no write reaches the memory, and `busy` and `done` stay 0.
- R4: `irq_n` is low exactly when `done` is 1 and the interrupt-enable bit is 1. Otherwise it is high.
- R5: During a pass, `busy` is high for exactly DEPTH cycles. In each of those cycles `ram_we` is 1 and `ram_wdata` is 0x00, and the address rises by one from one cycle to the next.
- R6: `done` is set on the clock edge that ends a pass. It is cleared by a one-cycle pulse on `done_rd` (flag read) or on `done_ack` (write of 1). If a pass ends in the same cycle as a clear, the set takes priority.
- R7: A `wipe_n` that stays low produces exactly one pass.
- R8: A new falling edge of `wipe_n` that arrives while `busy` is high is ignored.
- R9: While `busy` is high, host writes do not reach the memory and `host_rdata` reads 0x00. When `busy` is low, the host port passes straight through to the memory.
- R10: `ctl_we` loads the wipe-enable bit from `ctl_wipe_en` and the interrupt-enable bit from `ctl_irq_en`. Both bits are 0 after reset, and after reset `busy`, `done` and `ram_we` are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wipe_n | input | 1 | Asynchronous active-low wipe request pin |
| ctl_we | input | 1 | Loads the control bits |
| ctl_wipe_en | input | 1 | Wipe-enable value to load |
| ctl_irq_en | input | 1 | Interrupt-enable value to load |
| done_rd | input | 1 | Read strobe of the completion flag (clears it) |
| done_ack | input | 1 | Write-1 strobe to the completion flag (clears it) |
| host_addr | input | AW | Host memory address |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write enable |
| host_rdata | output | 8 | Host read data, 0x00 while busy |
| ram_addr | output | AW | Memory address |
| ram_wdata | output | 8 | Memory write data |
| ram_we | output | 1 | Memory write enable |
| ram_rdata | input | 8 | Memory read data |
| busy | output | 1 | High for the whole wipe pass |
| done | output | 1 | Completion flag |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
The assertions assume that `done_rd`, `done_ack` and `ctl_we` are single-cycle strobes and that the host port drives no address at or above 2^AW. They also assume that `wipe_n` may change at any time but is only observed after the synchroniser. The bench changes every input one time unit after a rising edge and holds `wipe_n` low for several cycles, so each request is seen cleanly. Host accesses use addresses below 256, and the bench issues strobes for exactly one cycle.

// File: rtl/ram_wipe_seq.sv
module ram_wipe_seq #(
  parameter int DEPTH = 242,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wipe_n,
  input  logic          ctl_we,
  input  logic          ctl_wipe_en,
  input  logic          ctl_irq_en,
  input  logic          done_rd,
  input  logic          done_ack,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  input  logic          host_we,
  output logic [7:0]    host_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          ram_we,
  input  logic [7:0]    ram_rdata,
  output logic          busy,
  output logic          done,
  output logic          irq_n
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          sync1, sync2, sync3;
  logic          wipe_en_q, irq_en_q;
  logic [AW-1:0] cnt;
  logic          fall, start, pass_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      sync3 <= 1'b1;
    end else begin
      sync1 <= wipe_n;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign fall     = sync3 & ~sync2;
  assign start    = fall & wipe_en_q & ~busy;
  assign pass_end = busy & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wipe_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
    end else if (ctl_we) begin
      wipe_en_q <= ctl_wipe_en;
      irq_en_q  <= ctl_irq_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      busy <= ~pass_end;
      cnt  <= pass_end ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                done <= 1'b0;
    else if (pass_end)         done <= 1'b1;
    else if (done_rd | done_ack) done <= 1'b0;
  end

  assign irq_n      = ~(done & irq_en_q);
  assign ram_addr   = busy ? cnt : host_addr;
  assign ram_wdata  = busy ? 8'h00 : host_wdata;
  assign ram_we     = busy | host_we;
  assign host_rdata = busy ? 8'h00 : ram_rdata;

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(ram_addr) < DEPTH)); // R1
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wipe_en_q)); // R2
  AST_IRQ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (done && irq_en_q)); // R4
  AST_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (ram_addr == $past(ram_addr) + 1'b1)); // R5
  AST_DONE_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !busy); // R8
endmodule

// File: tb/ram_wipe_seq_test.sv
module ram_wipe_seq_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 242;
  localparam int AW     = 8;

  logic clk = 0, rst_n = 0, wipe_n = 1;
  logic ctl_we = 0, ctl_wipe_en = 0, ctl_irq_en = 0, done_rd = 0, done_ack = 0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_we = 0;
  logic [7:0] host_rdata, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr;
  logic ram_we, busy, done, irq_n;

  logic [7:0] mem [0:255];
  logic [15:0] expq[$];
  int checks = 0, errors = 0, busy_cycles = 0;

  always #(PERIOD/2) clk = ~clk;

  ram_wipe_seq #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk, .rst_n, .wipe_n, .ctl_we, .ctl_wipe_en, .ctl_irq_en, .done_rd, .done_ack,
    .host_addr, .host_wdata, .host_we, .host_rdata, .ram_addr, .ram_wdata, .ram_we,
    .ram_rdata, .busy, .done, .irq_n);

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_we) mem[ram_addr] <= ram_wdata;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every memory write must match the next expected item
  always @(negedge clk) begin
    if (busy) busy_cycles++;
    if (rst_n && ram_we) begin
      if (expq.size() == 0) chk("R3/R7/R8 unexpected write", {ram_addr, ram_wdata}, 0);
      else chk("R1/R5 write", {ram_addr, ram_wdata}, expq.pop_front());
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host_write(input int a, input int d);
    expq.push_back({8'(a), 8'(d)});
    host_addr = 8'(a); host_wdata = 8'(d); host_we = 1;
    step(1);
    host_we = 0;
  endtask

  task automatic set_ctl(input logic we, input logic ie);
    ctl_wipe_en = we; ctl_irq_en = ie; ctl_we = 1;
    step(1);
    ctl_we = 0;
  endtask

  task automatic expect_pass();
    for (int i = 0; i < DEPTH; i++) expq.push_back({8'(i), 8'h00});
  endtask

  task automatic read_chk(input string req, input int a, input int exp);
    host_addr = 8'(a);
    #1 chk(req, host_rdata, exp);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset irq_n", irq_n, 1);
    chk("R10 reset ram_we", ram_we, 0);
    rst_n = 1;
    step(1);

    for (int i = 0; i < 256; i++) host_write(i, 8'h80 | (i & 8'h7f));
    step(1);
    chk("R9 host write path", mem[250], 8'h80 | 250 & 8'h7f);

    // R3: wipe disabled
    wipe_n = 0; step(6); wipe_n = 1;
    step(260);
    chk("R3 busy stays low", busy_cycles, 0);
    chk("R3 done stays low", done, 0);
    read_chk("R3 memory untouched", 5, 8'h85);

    // R2/R4/R5/R7/R8/R9: enabled pass with interrupt
    set_ctl(1, 1);
    expect_pass();
    wipe_n = 0;
    step(2);
    chk("R2 busy not yet", busy, 0);
    step(1);
    chk("R2 busy on third edge", busy, 1);
    read_chk("R9 read blocked", 250, 0);
    host_addr = 8'd245; host_wdata = 8'h11; host_we = 1;
    step(1);
    host_we = 0;
    step(20);
    wipe_n = 1; step(4); wipe_n = 0;
    step(300);
    chk("R5 busy length", busy_cycles, DEPTH);
    chk("R6 done set", done, 1);
    chk("R4 irq asserted", irq_n, 0);
    chk("R1/R7 queue drained", expq.size(), 0);
    chk("R1 addr 0 cleared", mem[0], 0);
    chk("R1 addr 241 cleared", mem[241], 0);
    chk("R1 addr 242 kept", mem[242], 8'h80 | 242 & 8'h7f);
    chk("R9 blocked write dropped", mem[245], 8'h80 | 245 & 8'h7f);
    read_chk("R9 read passes when idle", 250, 8'h80 | 250 & 8'h7f);

    done_rd = 1; step(1); done_rd = 0;
    chk("R6 read clears done", done, 0);
    chk("R4 irq released", irq_n, 1);

    // R4: interrupt disabled, R6 write-1 clear
    wipe_n = 1;
    set_ctl(1, 0);
    step(4);
    busy_cycles = 0;
    expect_pass();
    wipe_n = 0;
    step(260);
    chk("R5 second pass length", busy_cycles, DEPTH);
    chk("R6 done after second pass", done, 1);
    chk("R4 no irq when disabled", irq_n, 1);
    done_ack = 1; step(1); done_ack = 0;
    chk("R6 write-1 clears done", done, 0);
    chk("R10 queue drained", expq.size(), 0);
    wipe_n = 1;
    step(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule